// File: doc/BRIEF.md
# Privilege Mode and Trap Entry Controller

This block keeps the processor's privilege state and decides, every cycle, whether control must leave the running program. Sources are a device interrupt carrying a device number, a software trap (system call or divide-by-zero), and an illegal-instruction trap the block raises itself. The illegal-instruction trap fires when a privileged instruction, a vector-table write or a set-user command arrives in user mode. When one of these is taken, the block does four things in the next cycle. It drops to monitor mode, pulses a redirect strobe, and presents a handler address. It also saves the address of the interrupted instruction. The handler address comes from a small internal table of handler pointers.

The table is indexed by the device number for interrupts and by fixed indices for the software and illegal traps. Each entry can be rewritten, but only from monitor mode. Only an explicit set-user command, issued in monitor mode, moves the block back to user mode. A device interrupt that loses arbitration is held in a one-entry pending slot. It is taken as soon as no trap competes for that cycle.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset, the block is in monitor mode (mode_user = 0), redir_valid, ill_trap and ret_addr are 0, and table entry i holds i*16.
- R2: The mode bit reads 0 for monitor and 1 for user. A set_user in monitor mode with no event taken makes mode_user 1 after the next clock edge.
- R3: When any event is taken at a clock edge, after that edge mode_user is 0 and redir_valid is 1 for that one cycle. redir_addr then equals the table entry selected for the event.
- R4: A device interrupt uses the table entry equal to irq_dev (devices 0 to 12). A software trap uses entry 13 when swt_cause = 0 (system call) and entry 14 when swt_cause = 1 (divide-by-zero).
- R5: In user mode, insn_valid with insn_priv raises the illegal-instruction trap. That trap uses entry 15 and pulses ill_trap with redir_valid. In monitor mode the same input has no effect, and a non-privileged instruction never traps.
- R6: ret_addr takes the pc_in value of the cycle in which an event is taken. It holds that value until the next event is taken.
- R7: mode_user rises only through set_user. A set_user issued in user mode is itself an illegal-instruction trap, and the mode goes to monitor.
- R8: A vector-table write (vt_we, vt_idx, vt_wdata) in monitor mode updates the entry. Later redirects through that index return the new value.
- R9: When a software trap and a device interrupt arrive in the same cycle, the software trap is taken first. The interrupt is taken in the next free cycle, and its ret_addr is the pc_in of that later cycle.
- R10: A vector-table write in user mode leaves the table unchanged and raises the illegal-instruction trap.
- R11: An illegal-instruction trap takes priority over a software trap in the same cycle. The software trap request of that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Device interrupt request, one cycle |
| irq_dev | input | IDX_W | Device number of the request |
| swt_req | input | 1 | Software trap request |
| swt_cause | input | 1 | 0 system call, 1 divide-by-zero |
| insn_valid | input | 1 | An instruction issues this cycle |
| insn_priv | input | 1 | Issuing instruction is privileged (includes all I/O) |
| pc_in | input | ADDR_W | Address of the current instruction |
| set_user | input | 1 | Command to enter user mode |
| vt_we | input | 1 | Vector-table write request |
| vt_idx | input | IDX_W | Table entry to write |
| vt_wdata | input | ADDR_W | Handler address to store |
| mode_user | output | 1 | Mode bit: 0 monitor, 1 user |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_addr | output | ADDR_W | Handler address for the redirect |
| ret_addr | output | ADDR_W | Saved address of the interrupted instruction |
| ill_trap | output | 1 | Redirect is an illegal-instruction trap |

## Verification
The assertions assume that irq_dev stays below 13 whenever irq_req is high, so that device interrupts never alias the fixed trap indices. They also assume inputs are stable around the clock edge. The bench drives every input a quarter period after the edge. It uses device numbers 3, 5 and 7 only and returns each request to low after the cycle it is meant for. The pending-interrupt checks therefore only ever see a single interrupt waiting at a time.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IRQ  = 2'd1,
    SRC_SWT  = 2'd2,
    SRC_ILL  = 2'd3
  } src_e;

  // Reset contents of a table slot: evenly spaced handler stubs.
  function automatic int unsigned vec_reset(int unsigned idx, int unsigned stride);
    return idx * stride;
  endfunction

  // Fixed priority: illegal instruction, then software trap, then device.
  function automatic src_e pick_source(logic ill, logic swt, logic irq);
    if (ill)      return SRC_ILL;
    else if (swt) return SRC_SWT;
    else if (irq) return SRC_IRQ;
    else          return SRC_NONE;
  endfunction

endpackage

// File: rtl/ptc_vec_table.sv
module ptc_vec_table #(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 16,
  parameter int STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  import ptc_pkg::*;

  localparam int NVEC = 1 << IDX_W;

  logic [ADDR_W-1:0] slot_q [NVEC];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NVEC; i++) begin
      if (!rst_n)
        slot_q[i] <= ADDR_W'(vec_reset(i, STRIDE));
      else if (wr_en && (wr_idx == IDX_W'(i)))
        slot_q[i] <= wr_data;
    end
  end

  // Read returns the contents before any same-cycle write.
  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/ptc_arbiter.sv
module ptc_arbiter #(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_user,
  input  logic              insn_valid,
  input  logic              insn_priv,
  input  logic              set_user,
  input  logic              vt_we,
  input  logic              swt_req,
  input  logic              swt_cause,
  input  logic              irq_req,
  input  logic [IDX_W-1:0]  irq_dev,
  output logic              take,
  output logic              take_ill,
  output logic [IDX_W-1:0]  take_idx
);
  import ptc_pkg::*;

  localparam int NVEC = 1 << IDX_W;
  localparam logic [IDX_W-1:0] IDX_ILL  = IDX_W'(NVEC - 1);
  localparam logic [IDX_W-1:0] IDX_DIVZ = IDX_W'(NVEC - 2);
  localparam logic [IDX_W-1:0] IDX_SYSC = IDX_W'(NVEC - 3);

  logic             pend_v;
  logic [IDX_W-1:0] pend_dev;
  logic             ill_evt;
  logic             irq_avail;
  logic [IDX_W-1:0] irq_num;
  src_e             src;

  assign ill_evt   = mode_user & ((insn_valid & insn_priv) | vt_we | set_user);
  assign irq_avail = pend_v | irq_req;
  assign irq_num   = pend_v ? pend_dev : irq_dev;
  assign src       = pick_source(ill_evt, swt_req, irq_avail);

  always_comb begin
    unique case (src)
      SRC_ILL: take_idx = IDX_ILL;
      SRC_SWT: take_idx = swt_cause ? IDX_DIVZ : IDX_SYSC;
      SRC_IRQ: take_idx = irq_num;
      default: take_idx = '0;
    endcase
  end

  assign take     = (src != SRC_NONE);
  assign take_ill = (src == SRC_ILL);

  // One-entry pending slot for a device interrupt that lost arbitration.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_dev <= '0;
    end else if (src == SRC_IRQ) begin
      if (pend_v && irq_req) begin
        pend_v   <= 1'b1;
        pend_dev <= irq_dev;
      end else begin
        pend_v   <= 1'b0;
      end
    end else if (irq_req && !pend_v) begin
      pend_v   <= 1'b1;
      pend_dev <= irq_dev;
    end
  end

  AST_SWT_BEFORE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (swt_req && irq_req && !pend_v) |=> pend_v); // R9

  AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !swt_req && !ill_evt && !irq_req) |=> !pend_v); // R9

  AST_ILL_OVER_SWT: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_evt && swt_req) |-> (take_idx == IDX_ILL)); // R11

endmodule

// File: rtl/ptc_mode_ctl.sv
module ptc_mode_ctl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_ill,
  input  logic              set_user,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] vec_addr,
  output logic              mode_user,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              ill_trap
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_user   <= 1'b0;
      redir_valid <= 1'b0;
      redir_addr  <= '0;
      ret_addr    <= '0;
      ill_trap    <= 1'b0;
    end else begin
      redir_valid <= take;
      ill_trap    <= take_ill;
      if (take) begin
        mode_user  <= 1'b0;
        redir_addr <= vec_addr;
        ret_addr   <= pc_in;
      end else if (set_user) begin
        mode_user  <= 1'b1;
      end
    end
  end

  AST_TRAP_ENTERS_MONITOR: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !mode_user); // R3

  AST_USER_VIA_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_user) |-> $past(set_user)); // R7

  AST_RET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid |-> $stable(ret_addr)); // R6

  AST_ILL_WITH_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    ill_trap |-> redir_valid); // R5

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl #(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 16,
  parameter int STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [IDX_W-1:0]  irq_dev,
  input  logic              swt_req,
  input  logic              swt_cause,
  input  logic              insn_valid,
  input  logic              insn_priv,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              set_user,
  input  logic              vt_we,
  input  logic [IDX_W-1:0]  vt_idx,
  input  logic [ADDR_W-1:0] vt_wdata,
  output logic              mode_user,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              ill_trap
);

  logic              take;
  logic              take_ill;
  logic [IDX_W-1:0]  take_idx;
  logic [ADDR_W-1:0] vec_addr;
  logic              tbl_wr;

  assign tbl_wr = vt_we & ~mode_user;

  ptc_arbiter #(.IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .mode_user(mode_user),
    .insn_valid(insn_valid), .insn_priv(insn_priv), .set_user(set_user),
    .vt_we(vt_we), .swt_req(swt_req), .swt_cause(swt_cause),
    .irq_req(irq_req), .irq_dev(irq_dev),
    .take(take), .take_ill(take_ill), .take_idx(take_idx)
  );

  ptc_vec_table #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .wr_idx(vt_idx),
    .wr_data(vt_wdata), .rd_idx(take_idx), .rd_data(vec_addr)
  );

  ptc_mode_ctl #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .take(take), .take_ill(take_ill),
    .set_user(set_user), .pc_in(pc_in), .vec_addr(vec_addr),
    .mode_user(mode_user), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .ret_addr(ret_addr), .ill_trap(ill_trap)
  );

  AST_PRIV_USER_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_user && insn_valid && insn_priv) |=> (ill_trap && !mode_user)); // R5

  AST_USER_WRITE_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_user && vt_we) |=> ill_trap); // R10

  AST_SET_USER_IN_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_user && set_user) |=> (ill_trap && !mode_user)); // R7

endmodule

// File: tb/priv_trap_ctrl_tb.sv
module priv_trap_ctrl_tb;
  localparam int IDX_W  = 4;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 0, swt_req = 0, swt_cause = 0, insn_valid = 0, insn_priv = 0;
  logic set_user = 0, vt_we = 0;
  logic [IDX_W-1:0]  irq_dev = '0, vt_idx = '0;
  logic [ADDR_W-1:0] pc_in = '0, vt_wdata = '0;
  logic mode_user, redir_valid, ill_trap;
  logic [ADDR_W-1:0] redir_addr, ret_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [ADDR_W-1:0] exp_vec [16];

  always #4 clk = ~clk;

  priv_trap_ctrl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .STRIDE(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_dev(irq_dev),
    .swt_req(swt_req), .swt_cause(swt_cause), .insn_valid(insn_valid),
    .insn_priv(insn_priv), .pc_in(pc_in), .set_user(set_user),
    .vt_we(vt_we), .vt_idx(vt_idx), .vt_wdata(vt_wdata),
    .mode_user(mode_user), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .ret_addr(ret_addr), .ill_trap(ill_trap)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Advance one edge; inputs and samples sit 2 ns after it.
  task automatic go();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    irq_req = 0; swt_req = 0; insn_valid = 0; insn_priv = 0;
    set_user = 0; vt_we = 0;
  endtask

  task automatic enter_user();
    set_user = 1; go(); set_user = 0;
    chk("R2 set_user enters user", mode_user, 1);
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); repeat (3) go();
    chk("R1 reset mode", mode_user, 0);
    chk("R1 reset redir", redir_valid, 0);
    chk("R1 reset ill", ill_trap, 0);
    rst_n = 1; go();
    chk("R1 ret after reset", ret_addr, 0);
    chk("R1 mode after reset", mode_user, 0);
  endtask

  task automatic t_irq(logic [3:0] dev, logic [15:0] pc, string req);
    irq_req = 1; irq_dev = dev; pc_in = pc; go(); idle();
    chk({req, " irq redir"}, redir_valid, 1);
    chk({req, " irq addr"}, redir_addr, exp_vec[dev]);
    chk("R6 irq ret", ret_addr, pc);
    chk("R3 irq monitor", mode_user, 0);
    pc_in = pc + 16'h40; go();
    chk("R3 strobe one cycle", redir_valid, 0);
    chk("R6 ret held", ret_addr, pc);
  endtask

  task automatic t_swt(logic cause, logic [15:0] pc);
    enter_user();
    swt_req = 1; swt_cause = cause; pc_in = pc; go(); idle();
    chk("R4 swt redir", redir_valid, 1);
    chk("R4 swt addr", redir_addr, cause ? exp_vec[14] : exp_vec[13]);
    chk("R3 swt monitor", mode_user, 0);
    chk("R6 swt ret", ret_addr, pc);
    go();
  endtask

  task automatic t_priv();
    insn_valid = 1; insn_priv = 1; go(); idle();
    chk("R5 priv in monitor no trap", redir_valid, 0);
    enter_user();
    insn_valid = 1; insn_priv = 0; go(); idle();
    chk("R5 normal insn no trap", redir_valid, 0);
    chk("R5 normal insn stays user", mode_user, 1);
    insn_valid = 1; insn_priv = 1; pc_in = 16'h0A0A; go(); idle();
    chk("R5 priv user ill", ill_trap, 1);
    chk("R5 priv user addr", redir_addr, exp_vec[15]);
    chk("R5 priv user monitor", mode_user, 0);
    go();
    chk("R5 ill pulse ends", ill_trap, 0);
  endtask

  task automatic t_write_monitor();
    vt_we = 1; vt_idx = 4'd7; vt_wdata = 16'hBEEF; go(); idle();
    exp_vec[7] = 16'hBEEF;
    chk("R8 write no redirect", redir_valid, 0);
    t_irq(4'd7, 16'h2222, "R8");
  endtask

  task automatic t_write_user();
    enter_user();
    vt_we = 1; vt_idx = 4'd7; vt_wdata = 16'h1111; go(); idle();
    chk("R10 user write ill", ill_trap, 1);
    chk("R10 user write addr", redir_addr, exp_vec[15]);
    go();
    t_irq(4'd7, 16'h3333, "R10");
  endtask

  task automatic t_simul();
    enter_user();
    swt_req = 1; swt_cause = 0; irq_req = 1; irq_dev = 4'd3; pc_in = 16'h0100;
    go(); idle(); pc_in = 16'h0200;
    chk("R9 swt first addr", redir_addr, exp_vec[13]);
    chk("R9 swt first ret", ret_addr, 16'h0100);
    go();
    chk("R9 irq next redir", redir_valid, 1);
    chk("R9 irq next addr", redir_addr, exp_vec[3]);
    chk("R9 irq next ret", ret_addr, 16'h0200);
    go();
    chk("R9 pending drained", redir_valid, 0);
  endtask

  task automatic t_ill_vs_swt();
    enter_user();
    insn_valid = 1; insn_priv = 1; swt_req = 1; swt_cause = 1; go(); idle();
    chk("R11 ill wins", ill_trap, 1);
    chk("R11 ill addr", redir_addr, exp_vec[15]);
    go();
    chk("R11 swt dropped", redir_valid, 0);
  endtask

  task automatic t_set_user_in_user();
    enter_user();
    set_user = 1; go(); idle();
    chk("R7 set_user in user traps", ill_trap, 1);
    chk("R7 mode back to monitor", mode_user, 0);
    go();
    chk("R7 no spontaneous user", mode_user, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_vec[i] = 16'(i * 16);
    t_reset();
    t_irq(4'd5, 16'h1234, "R1");
    t_swt(1'b0, 16'h0044);
    t_swt(1'b1, 16'h0048);
    t_priv();
    t_write_monitor();
    t_write_user();
    t_simul();
    t_ill_vs_swt();
    t_set_user_in_user();
    summary();
  end

endmodule